// File: doc/BRIEF.md
# Battery-Low Check Scheduler

This controller decides when the backup battery is tested and keeps a sticky battery-low indication for the system. A test runs whenever main power becomes good. While power stays good, it runs again after a long interval that is set in clock cycles. A test can also be requested from outside. During a test the block raises a sample request to the analog comparator. It waits a settling time and then takes the digitized comparator result exactly once.

The low indication is latched. It can be cleared only by a later test that finds the battery good, either at the next power-up or at the next scheduled or requested test. No test runs while main power is bad. The interval count freezes during such outages, and the flag keeps its value. A second output records whether the latest low result came from a power-up test or from an in-service test. A low result at power-up means the stored data is suspect. A low result in service means the battery is near end of life.

Top module: `batt_low_monitor`

## Requirements
- R1: While reset is held, batt_low_n is 1 (battery good), smp_req is 0 and low_at_pwrup is 0.
- R2: At the first clock edge where pwr_ok is seen 1 after being seen 0 (including the first after reset), a test starts, and smp_req is 1 from that edge on. This power-up start takes priority over the other start causes.
- R3: During a test, smp_req stays 1 for exactly SETTLE_CYCLES clock cycles. batt_below is sampled only at the edge that ends this window. At any other time batt_below has no effect on the outputs.
- R4: At the end of a test, batt_low_n becomes 0 if batt_below (1 = battery under threshold) was 1, and becomes 1 otherwise. Between test ends, batt_low_n keeps its value.
- R5: While pwr_ok stays 1, a test starts INTERVAL_CYCLES cycles after the edge that completed the previous test. This holds whether the previous test was a power-up, interval or requested test.
- R6: No test starts while pwr_ok is 0. If pwr_ok drops during a test, the test is abandoned: smp_req goes to 0 and no result is taken. While pwr_ok is 0 the interval count is paused, not restarted.
- R7: batt_low_n and low_at_pwrup hold their values through any period with pwr_ok at 0.
- R8: When a test ends with a low result, low_at_pwrup becomes 1 if that test was started by power-up and 0 otherwise. It does not change at any other time.
- R9: A 1 on chk_req starts an in-service test at that edge when pwr_ok is 1 and no test is running. chk_req is ignored during a test or while pwr_ok is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_ok | input | 1 | Main supply within tolerance |
| chk_req | input | 1 | External request for an in-service test |
| batt_below | input | 1 | Comparator result, 1 = battery under threshold |
| batt_low_n | output | 1 | Sticky battery-low flag, active low |
| smp_req | output | 1 | Request to the comparator to sample the battery |
| low_at_pwrup | output | 1 | Latest low result came from a power-up test |

## Verification
The assertions assume that pwr_ok, chk_req and batt_below are synchronous to clk and stable around each rising edge. They also assume that reset starts with pwr_ok at 0 or treats the first high sample as a power-up. The bench changes every input only on the falling clock edge. It applies directed sequences for power-up, interval, requested and abandoned tests, and then applies random power dropouts and comparator values that always stay synchronous. A behavioural reference model advances on each rising edge and is compared with all three outputs on every falling edge.

// File: rtl/batt_low_monitor.sv
module batt_low_monitor #(
  parameter longint unsigned INTERVAL_CYCLES = 64'd8_640_000_000_000,
  parameter int unsigned     SETTLE_CYCLES   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok,
  input  logic chk_req,
  input  logic batt_below,
  output logic batt_low_n,
  output logic smp_req,
  output logic low_at_pwrup
);
  localparam int IW = $clog2(INTERVAL_CYCLES + 1);
  localparam int SW = $clog2(SETTLE_CYCLES + 1);

  logic          pwr_q;
  logic          kind_pwr;
  logic [SW-1:0] set_cnt;
  logic [IW-1:0] ivl_cnt;

  wire pwr_rise = pwr_ok & ~pwr_q;
  wire ivl_due  = (ivl_cnt == IW'(INTERVAL_CYCLES - 1));
  wire start    = pwr_ok & ~smp_req & (pwr_rise | ivl_due | chk_req);
  wire done     = pwr_ok & smp_req & (set_cnt == SW'(SETTLE_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q        <= 1'b0;
      kind_pwr     <= 1'b0;
      set_cnt      <= '0;
      ivl_cnt      <= '0;
      smp_req      <= 1'b0;
      batt_low_n   <= 1'b1;
      low_at_pwrup <= 1'b0;
    end else begin
      pwr_q <= pwr_ok;
      if (!pwr_ok) begin
        smp_req <= 1'b0;
      end else if (start) begin
        smp_req  <= 1'b1;
        set_cnt  <= '0;
        kind_pwr <= pwr_rise;
      end else if (done) begin
        smp_req    <= 1'b0;
        batt_low_n <= ~batt_below;
        if (batt_below) low_at_pwrup <= kind_pwr;
      end else if (smp_req) begin
        set_cnt <= set_cnt + 1'b1;
      end
      if (done)
        ivl_cnt <= '0;
      else if (pwr_ok && !smp_req && !start)
        ivl_cnt <= ivl_cnt + 1'b1;
    end
  end

  AST_REQ_NEEDS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
    smp_req |-> $past(pwr_ok)); // R6
  AST_FLAG_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> $stable(batt_low_n) && $stable(low_at_pwrup)); // R7
  AST_FLAG_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(batt_low_n) |-> $fell(smp_req)); // R4
  AST_SRC_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(low_at_pwrup) |-> ($fell(smp_req) && !batt_low_n)); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ivl_cnt <= IW'(INTERVAL_CYCLES - 1)); // R5
endmodule

// File: tb/batt_low_monitor_test.sv
module batt_low_monitor_test;
  localparam int IVL = 40;
  localparam int SET = 4;

  logic clk = 0, rst_n = 0, pwr_ok = 0, chk_req = 0, batt_below = 0;
  logic batt_low_n, smp_req, low_at_pwrup;
  int checks = 0, errors = 0, cyc = 0;

  batt_low_monitor #(.INTERVAL_CYCLES(IVL), .SETTLE_CYCLES(SET)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .chk_req(chk_req),
    .batt_below(batt_below), .batt_low_n(batt_low_n), .smp_req(smp_req),
    .low_at_pwrup(low_at_pwrup));

  always #5 clk = ~clk;

  // behavioural reference
  bit m_busy = 0, m_kind = 0, m_prev = 0, m_flag = 1, m_src = 0;
  int m_wait = 0, m_idle = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_kind = 0; m_prev = 0; m_flag = 1; m_src = 0; m_wait = 0; m_idle = 0;
    end else begin
      bit rise;
      rise = pwr_ok && !m_prev;
      m_prev = pwr_ok;
      if (!pwr_ok) m_busy = 0;
      else if (m_busy) begin
        m_wait++;
        if (m_wait == SET) begin
          m_busy = 0; m_idle = 0; m_flag = !batt_below;
          if (batt_below) m_src = m_kind;
        end
      end else begin
        m_idle++;
        if (rise || chk_req || m_idle == IVL) begin
          m_busy = 1; m_wait = 0; m_kind = rise; m_idle--;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  bit cmp_on = 0;
  always @(negedge clk) begin
    cyc++;
    if (cmp_on) begin
      chk(smp_req == m_busy, "R3 smp_req", smp_req, m_busy);
      chk(batt_low_n == m_flag, "R4 batt_low_n", batt_low_n, m_flag);
      chk(low_at_pwrup == m_src, "R8 low_at_pwrup", low_at_pwrup, m_src);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
  end

  initial begin
    int hi, lo;
    step(3);
    chk(batt_low_n == 1 && smp_req == 0 && low_at_pwrup == 0, "R1 reset",
        {batt_low_n, smp_req, low_at_pwrup}, 3'b100);
    rst_n = 1;
    cmp_on = 1;
    step(2);
    // R2: power-up check with low battery
    pwr_ok = 1; batt_below = 1;
    step(1);
    chk(smp_req == 1, "R2 start on power-up", smp_req, 1);
    hi = 1;
    while (smp_req) begin step(1); if (smp_req) hi++; end
    chk(hi == SET, "R3 settle length", hi, SET);
    chk(batt_low_n == 0 && low_at_pwrup == 1, "R8 power-up low", {batt_low_n, low_at_pwrup}, 2'b01);
    // R3: batt_below changes while idle have no effect
    batt_below = 0; step(5); batt_below = 1; step(5);
    chk(batt_low_n == 0, "R3 ignored while idle", batt_low_n, 0);
    // R5: interval spacing, good battery clears flag
    batt_below = 0;
    lo = 10;
    while (!smp_req) begin step(1); lo++; end
    chk(lo == IVL, "R5 interval spacing", lo, IVL);
    step(SET);
    chk(batt_low_n == 1, "R4 cleared by good test", batt_low_n, 1);
    // interval test finding low
    batt_below = 1;
    while (!smp_req) step(1);
    step(SET);
    chk(batt_low_n == 0 && low_at_pwrup == 0, "R8 interval low", {batt_low_n, low_at_pwrup}, 2'b00);
    // R6/R7: outage with paused interval count
    step(20); pwr_ok = 0; chk_req = 1;
    hi = 0;
    repeat (60) begin step(1); hi += smp_req; end
    chk_req = 0;
    chk(hi == 0, "R6 no test during outage", hi, 0);
    chk(batt_low_n == 0 && low_at_pwrup == 0, "R7 hold during outage", {batt_low_n, low_at_pwrup}, 2'b00);
    // power returns with good battery
    batt_below = 0; pwr_ok = 1; step(1);
    chk(smp_req == 1, "R2 restart after outage", smp_req, 1);
    step(SET);
    chk(batt_low_n == 1, "R4 power-up clears", batt_low_n, 1);
    // R9: external request, ignored mid-test
    step(3); batt_below = 1; chk_req = 1; step(1); chk_req = 0;
    chk(smp_req == 1, "R9 request starts test", smp_req, 1);
    step(1); chk_req = 1; step(1); chk_req = 0;
    step(SET - 2);
    chk(smp_req == 0 && batt_low_n == 0 && low_at_pwrup == 0, "R9 requested low",
        {smp_req, batt_low_n, low_at_pwrup}, 3'b000);
    // R6: abandon mid-test
    batt_below = 0; chk_req = 1; step(1); chk_req = 0; step(1);
    pwr_ok = 0; step(1);
    chk(smp_req == 0 && batt_low_n == 0, "R6 abandoned test", {smp_req, batt_low_n}, 2'b00);
    pwr_ok = 1; step(SET + 2);
    chk(batt_low_n == 1, "R2 retest after abandon", batt_low_n, 1);
    // random phase against the model
    repeat (4000) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 3) pwr_ok = !pwr_ok;
      chk_req = ($urandom_range(0, 29) == 0);
      batt_below = $urandom_range(0, 1);
      step(1);
    end
    summary();
  end
endmodule